// File: doc/BRIEF.md
# Shared Count Timer with Per-Processor Compare Interrupts

This block keeps one 64-bit up-counter that every processor in a cluster shares as a common time base. The counter advances by one on each clock where the `tick` enable is high, unless software has set the halt bit in the control word. Software reaches the counter through a 32-bit register bus as two 32-bit halves, a low word and a high word. Each half can be read and written on its own.

Each processor has its own 64-bit compare value. When the shared counter equals a processor's compare value, that processor's interrupt line goes high. The line stays high until software writes either half of that compare value again. The number of processors is a parameter, from 1 to 4.

Register map (byte addresses). Control word at 0x00: bit 28 is the halt bit (read/write), bits 27:24 hold the width code (read-only), and all other bits read 0. The counter low word is at 0x10 and the high word at 0x14. Processor p has its compare low word at 0x20+8p and its compare high word at 0x24+8p.

Top module: `gct_timer`

## Requirements
- R1: While `rst` is high and after it is released, the following hold: counter = 0, halt bit = 0, every `irq` bit = 0, `rd_data` = 0, and every compare word reads 0xFFFFFFFF.
- R2: When `tick`=1, the halt bit is 0 and no counter write is made, the counter rises by exactly one at the clock edge. With `tick`=0 it holds its value.
- R3: Writing bit 28 of the control word at 0x00 sets the halt bit. The bit reads back at bit 28. While it is 1, the counter does not change on `tick`.
- R4: Control bits 27:24 always read 4'h8, meaning a 64-bit counter (width = 32 + 4*code). Writes to them, and to every other control bit except bit 28, have no effect, and those other bits read 0.
- R5: A write to 0x10 (low word) or 0x14 (high word) loads that half at the clock edge and leaves the other half unchanged. The write takes precedence over a `tick` increment in the same cycle.
- R6: Processor p's compare low word is at 0x20+8p and its high word at 0x24+8p. Both read back what was last written.
- R7: `irq[p]` goes to 1 on the clock edge after a cycle in which the counter equals compare p, unless compare p is written in that same cycle.
- R8: Once set, `irq[p]` stays at 1 until either half of compare p is written. It is 0 after that write's clock edge, even when the counter matched compare p in the write cycle.
- R9: Read data appears on `rd_data` on the edge after `bus_rd` and holds until the next read. A read of an unmapped address returns 0.
- R10: A carry out of the low word increments the high word on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for the shared counter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address for the read or write |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | NUM_CPU | Compare interrupt, one bit per processor |

## Verification
Two pairs of events can land in the same cycle. In the first, a counter-half write and a `tick` fall on the same clock edge. The bench drives both in one cycle and expects the written value, with no increment. In the second, a compare write arrives while the counter already equals that compare value. The bench rewrites the matching value. It then expects `irq` low for one cycle after the write and high again on the next cycle, because the match is still present.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int BUS_W       = 32;
  localparam int CFG_ADDR    = 'h00;
  localparam int CNT_LO_ADDR = 'h10;
  localparam int CNT_HI_ADDR = 'h14;
  localparam int CMP_BASE    = 'h20;
  localparam int CMP_STRIDE  = 8;
  localparam int HALT_BIT    = 28;
  localparam int WCODE_LSB   = 24;
  localparam int WCODE_W     = 4;

  function automatic logic [WCODE_W-1:0] width_code(input int cnt_w);
    return WCODE_W'((cnt_w - 32) / 4);
  endfunction
endpackage

// File: rtl/gct_counter.sv
module gct_counter #(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               halt,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0]   cnt_q
);
  localparam int HALF_W = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_q[HALF_W-1:0]     <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:HALF_W] <= wdata;
    end else if (tick && !halt) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2 R10
  cnt_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !halt && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !wr_lo && !wr_hi) |=> $stable(cnt_q));

  // R5
  wr_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> (cnt_q[HALF_W-1:0] == $past(wdata)) &&
                          (cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W])));
endmodule

// File: rtl/gct_cmp_unit.sv
module gct_cmp_unit #(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wdata,
  output logic [CNT_W-1:0]   cmp_q,
  output logic               irq_q
);
  localparam int HALF_W = CNT_W / 2;

  logic wr_any;
  logic hit;

  assign wr_any = wr_lo || wr_hi;
  assign hit    = (cnt == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
    end else begin
      if (wr_lo) cmp_q[HALF_W-1:0]     <= wdata;
      if (wr_hi) cmp_q[CNT_W-1:HALF_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         irq_q <= 1'b0;
    else if (wr_any) irq_q <= 1'b0;
    else if (hit)    irq_q <= 1'b1;
  end

  // R1
  cmp_rst_chk: assert property (@(posedge clk)
    rst |=> (cmp_q == '1) && !irq_q);

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == cmp_q && !wr_any) |=> irq_q);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !wr_any) |=> irq_q);

  // R8
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_any |=> !irq_q);
endmodule

// File: rtl/gct_rdmux.sv
module gct_rdmux
  import gct_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     halt,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [NUM_CPU*CNT_W-1:0] cmp_flat,
  output logic [BUS_W-1:0]         rd_data
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [WCODE_W-1:0] WCODE = width_code(CNT_W);

  logic [BUS_W-1:0] nxt;
  logic             hit;

  always_comb begin
    nxt = '0;
    hit = 1'b0;
    if (addr == ADDR_W'(CFG_ADDR)) begin
      hit = 1'b1;
      nxt[HALT_BIT] = halt;
      nxt[WCODE_LSB +: WCODE_W] = WCODE;
    end
    if (addr == ADDR_W'(CNT_LO_ADDR)) begin
      hit = 1'b1;
      nxt = cnt[HALF_W-1:0];
    end
    if (addr == ADDR_W'(CNT_HI_ADDR)) begin
      hit = 1'b1;
      nxt = cnt[CNT_W-1:HALF_W];
    end
    for (int p = 0; p < NUM_CPU; p++) begin
      if (addr == ADDR_W'(CMP_BASE + CMP_STRIDE*p)) begin
        hit = 1'b1;
        nxt = cmp_flat[p*CNT_W +: HALF_W];
      end
      if (addr == ADDR_W'(CMP_BASE + CMP_STRIDE*p + 4)) begin
        hit = 1'b1;
        nxt = cmp_flat[p*CNT_W + HALF_W +: HALF_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= nxt;
  end

  // R4
  wcode_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(CFG_ADDR)) |=> rd_data[WCODE_LSB +: WCODE_W] == WCODE);

  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit) |=> rd_data == '0);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/gct_timer.sv
module gct_timer
  import gct_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic [NUM_CPU-1:0] irq
);
  localparam int HALF_W = CNT_W / 2;

  logic                     halt_q;
  logic [CNT_W-1:0]         cnt;
  logic [NUM_CPU*CNT_W-1:0] cmp_flat;
  logic                     cnt_wr_lo;
  logic                     cnt_wr_hi;

  assign cnt_wr_lo = bus_wr && (bus_addr == ADDR_W'(CNT_LO_ADDR));
  assign cnt_wr_hi = bus_wr && (bus_addr == ADDR_W'(CNT_HI_ADDR));

  always_ff @(posedge clk) begin
    if (rst) halt_q <= 1'b0;
    else if (bus_wr && bus_addr == ADDR_W'(CFG_ADDR)) halt_q <= bus_wdata[HALT_BIT];
  end

  gct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .halt  (halt_q),
    .wr_lo (cnt_wr_lo),
    .wr_hi (cnt_wr_hi),
    .wdata (bus_wdata[HALF_W-1:0]),
    .cnt_q (cnt)
  );

  for (genvar p = 0; p < NUM_CPU; p++) begin : g_cpu
    logic wr_lo;
    logic wr_hi;
    assign wr_lo = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + CMP_STRIDE*p));
    assign wr_hi = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + CMP_STRIDE*p + 4));

    gct_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .clk   (clk),
      .rst   (rst),
      .cnt   (cnt),
      .wr_lo (wr_lo),
      .wr_hi (wr_hi),
      .wdata (bus_wdata[HALF_W-1:0]),
      .cmp_q (cmp_flat[p*CNT_W +: CNT_W]),
      .irq_q (irq[p])
    );
  end

  gct_rdmux #(.CNT_W(CNT_W), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .halt     (halt_q),
    .cnt      (cnt),
    .cmp_flat (cmp_flat),
    .rd_data  (rd_data)
  );

  // R3
  halt_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(CFG_ADDR)) |=> halt_q == $past(bus_wdata[HALT_BIT]));
endmodule

// File: tb/gct_timer_bench.sv
module gct_timer_bench;
  localparam int NUM_CPU = 2;
  localparam int ADDR_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       rd_data;
  logic [NUM_CPU-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        issued = 1'b0;

  always #4 clk = ~clk;

  gct_timer #(.CNT_W(64), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_gct_timer (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver tasks: entered and left at a falling edge.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick_n(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic [NUM_CPU-1:0] exp, input string tag);
    check(irq === exp, tag, 32'(irq), 32'(exp));
  endtask

  // Monitor: pops one expected item per completed read.
  always @(posedge clk) issued <= bus_rd;
  always @(negedge clk) begin
    if (issued) begin
      logic [31:0] e;
      string t;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected read data", rd_data, 32'h0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq('0, "R1 irq after reset");
    check(rd_data === 32'h0, "R1 rd_data after reset", rd_data, 32'h0);
    rd(8'h10, 32'h0, "R1 counter low");
    rd(8'h14, 32'h0, "R1 counter high");
    rd(8'h20, 32'hFFFF_FFFF, "R1 cmp0 low");
    rd(8'h2C, 32'hFFFF_FFFF, "R1 cmp1 high");
    rd(8'h00, 32'h0800_0000, "R4 control word after reset");

    // R2 counting and holding
    tick_n(5);
    rd(8'h10, 32'd5, "R2 count after 5 ticks");
    repeat (3) @(negedge clk);
    rd(8'h10, 32'd5, "R2 hold with tick low");

    // R3 / R4 halt and read-only width code
    wr(8'h00, 32'h1F00_00FF);
    rd(8'h00, 32'h1800_0000, "R3 R4 control readback");
    tick_n(4);
    rd(8'h10, 32'd5, "R3 halted counter");
    wr(8'h00, 32'h0);
    tick_n(2);
    rd(8'h10, 32'd7, "R3 resumed counter");

    // R5 / R10 half writes and carry
    wr(8'h10, 32'hFFFF_FFFE);
    wr(8'h14, 32'h0000_0001);
    rd(8'h14, 32'h1, "R5 high write");
    tick_n(3);
    rd(8'h10, 32'h1, "R10 low wrapped");
    rd(8'h14, 32'h2, "R10 carry into high");
    tick = 1'b1;
    wr(8'h10, 32'h100);
    tick = 1'b0;
    rd(8'h10, 32'h100, "R5 write beats tick");
    rd(8'h14, 32'h2, "R5 other half unchanged");

    // R6 / R7 compare match
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h24, 32'h0);
    wr(8'h20, 32'd10);
    rd(8'h20, 32'd10, "R6 cmp0 low readback");
    tick_n(9);
    chk_irq(2'b00, "R7 no irq before match");
    tick_n(1);
    chk_irq(2'b00, "R7 irq not yet in match cycle");
    @(negedge clk);
    chk_irq(2'b01, "R7 irq0 set after match");

    // R8 sticky and cleared by compare write
    tick_n(3);
    chk_irq(2'b01, "R8 irq0 sticky past match");
    wr(8'h20, 32'd20);
    chk_irq(2'b00, "R8 irq0 cleared by cmp write");
    rd(8'h20, 32'd20, "R6 cmp0 rewritten");

    // R8 collision: compare write while already matching
    wr(8'h20, 32'd13);
    chk_irq(2'b00, "R8 no irq in write cycle");
    @(negedge clk);
    chk_irq(2'b01, "R7 irq0 on new match");
    wr(8'h20, 32'd13);
    chk_irq(2'b00, "R8 write clears during match");
    @(negedge clk);
    chk_irq(2'b01, "R7 irq0 re-set on held match");
    wr(8'h24, 32'h5);
    chk_irq(2'b00, "R8 high-half write clears");
    @(negedge clk);
    chk_irq(2'b00, "R8 stays clear without match");

    // R6 processor 1 and R9 unmapped
    wr(8'h28, 32'h77);
    rd(8'h28, 32'h77, "R6 cmp1 low readback");
    rd(8'h2C, 32'hFFFF_FFFF, "R6 cmp1 high untouched");
    rd(8'h40, 32'h0, "R9 unmapped read");
    repeat (2) @(negedge clk);
    check(rd_data === 32'h0, "R9 rd_data holds", rd_data, 32'h0);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule